// File: doc/BRIEF.md
# Single-Event Upset Injection Scheduler

This block emulates a radiation-induced bit upset in a design under test. It holds the register file that stands for the target's flip-flops. Each time the design advances, the file loads the next state that the design's logic supplies. At one programmed cycle of a run, the scheduler holds the design for a single clock instead. In that clock it performs a read-modify-write: it reads the whole file, inverts one, two or three chosen bits, and writes the result back. The target logic itself carries no extra fault logic.

A run begins with a start pulse. Three settings define the fault:

- **When:** the injection cycle, which must lie inside a window given by a low and a high cycle bound.
- **Where:** an enable mask that names the eligible flip-flops, together with a target index.
- **How:** the flip model, which sets how many adjacent enabled bits are inverted.

All settings are checked and captured at the start pulse. A configuration that cannot be honoured raises an error flag, and the run then proceeds with no fault at all. A stepping mode lets the host advance the design one clock per request, so a run can be walked through cycle by cycle.

Top module: `seu_injector`

## Requirements
- R1: After reset the state file and cycle counter read zero, done, err and armed are low, and the design does not advance until the first start pulse.
- R2: Once a run is started, every cycle with dut_ce high loads dut_next into the state file and adds one to cycle_count. The clock edge that takes start clears cycle_count to zero and does not advance the design.
- R3: When cycle_count equals the captured injection cycle, the design is held for one clock. In that clock the state file is rewritten with its own contents XOR the flip mask, and cycle_count does not change. Only one injection happens per run.
- R4: done is high for exactly one cycle, the cycle right after the write-back. By then dut_state already shows the flipped value.
- R5: If the injection cycle is below cfg_win_lo or above cfg_win_hi, err is set at the start edge and no injection happens. Both bounds are inclusive.
- R6: If the target bit is not set in cfg_enable, or the target index is not below WIDTH, err is set and no injection happens.
- R7: cfg_model encodings and their flip masks:
  - 0: flips only the target bit.
  - 1: also flips the first enabled index above the target, searching upward and wrapping from the top index to 0.
  - 2: also flips the enabled index after that one.
- R8: cfg_model value 3 sets err and injects nothing. So does a model that needs more enabled bits than cfg_enable holds.
- R9: While step_mode is high, the design advances by exactly one cycle for each cycle in which step_req is high, and it holds otherwise. A due injection still takes place without a step request.
- R10: The injection cycle and flip mask are captured at start. Later changes to the cfg_* inputs during the run have no effect on it.
- R11: A start pulse during any run restarts the run: cycle_count returns to zero, and err and done are recomputed from the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that validates and captures settings and begins a run |
| step_mode | input | 1 | High: the design advances only on step_req |
| step_req | input | 1 | Request for one design clock in step mode |
| cfg_inj_cycle | input | CYC_W | Cycle at which the upset is applied |
| cfg_win_lo | input | CYC_W | Lowest allowed injection cycle |
| cfg_win_hi | input | CYC_W | Highest allowed injection cycle |
| cfg_enable | input | WIDTH | Flip-flops eligible for flipping |
| cfg_target | input | IDX_W | Index of the first flipped bit |
| cfg_model | input | 2 | Flip model: 0 single, 1 double, 2 triple, 3 invalid |
| dut_next | input | WIDTH | Next state computed by the design's logic |
| dut_state | output | WIDTH | Current contents of the emulated flip-flops |
| dut_ce | output | 1 | High in cycles where the design advances |
| cycle_count | output | CYC_W | Design clocks since the last start |
| armed | output | 1 | A valid injection is pending |
| done | output | 1 | One-cycle pulse after the write-back |
| err | output | 1 | Settings of the current run were rejected |

## Verification
The assertions assume three things about the inputs:

- start is a single-cycle pulse.
- dut_next is a settled function of the state while dut_ce is high.
- step_req carries meaning only while step_mode is high.

The stimulus drives every input half a clock away from the active edge. It raises start for exactly one cycle, and it computes dut_next as the current state plus one. This lets every expected state be worked out as the state at start plus the number of advances, XOR the reference mask. Step requests are given only as single-cycle pulses, with step_mode held steady across each run.

// File: rtl/seu_inj_pkg.sv
package seu_inj_pkg;

  typedef enum logic [1:0] {
    FLIP_ONE   = 2'd0,
    FLIP_TWO   = 2'd1,
    FLIP_THREE = 2'd2,
    FLIP_BAD   = 2'd3
  } flip_model_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ARMED = 2'd1,
    PH_SPENT = 2'd2
  } run_phase_e;

endpackage

// File: rtl/seu_cycle_counter.sv
module seu_cycle_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count
);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count_q <= '0;
    end else if (inc) begin
      count_q <= count_q + CW'(1);
    end
  end

  assign count = count_q;

  // R11
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));

endmodule

// File: rtl/seu_flip_mask.sv
module seu_flip_mask
  import seu_inj_pkg::*;
#(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic [W-1:0]  enable,
  input  logic [IW-1:0] target,
  input  logic [1:0]    model,
  output logic [W-1:0]  mask,
  output logic          ok
);

  logic          in_range;
  logic [W-1:0]  rot;
  logic [W-1:0]  rest1;
  logic [W-1:0]  pick1;
  logic [W-1:0]  rest2;
  logic [W-1:0]  pick2;
  logic [W-1:0]  rmask;
  flip_model_e   mdl;

  always_comb begin
    mdl      = flip_model_e'(model);
    in_range = (int'(target) < W);
    // rotate so the target sits at bit 0; upward search then wraps naturally
    rot   = in_range ? ((enable >> target) | (enable << (W - int'(target)))) : '0;
    rest1 = rot & ~W'(1);
    pick1 = rest1 & (~rest1 + W'(1));
    rest2 = rest1 & ~pick1;
    pick2 = rest2 & (~rest2 + W'(1));
    case (mdl)
      FLIP_ONE: begin
        rmask = W'(1);
        ok    = rot[0];
      end
      FLIP_TWO: begin
        rmask = W'(1) | pick1;
        ok    = rot[0] && (|pick1);
      end
      FLIP_THREE: begin
        rmask = W'(1) | pick1 | pick2;
        ok    = rot[0] && (|pick1) && (|pick2);
      end
      default: begin
        rmask = '0;
        ok    = 1'b0;
      end
    endcase
    mask = ok ? ((rmask << target) | (rmask >> (W - int'(target)))) : '0;
  end

  always_comb begin
    if (ok) begin
      // R7
      mask_pop_chk: assert ($countones(mask) == int'(model) + 1);
      // R6
      mask_target_chk: assert (enable[target] && mask[target]);
      // R7
      mask_subset_chk: assert ((mask & ~enable) == '0);
    end
  end

endmodule

// File: rtl/seu_state_file.sv
module seu_state_file #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data
);

  logic [W-1:0] cells_q;

  for (genvar b = 0; b < W; b++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) begin
        cells_q[b] <= 1'b0;
      end else if (wr_en) begin
        cells_q[b] <= wr_data[b];
      end
    end
  end

  assign rd_data = cells_q;

endmodule

// File: rtl/seu_injector.sv
module seu_injector
  import seu_inj_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CYC_W = 16,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             step_mode,
  input  logic             step_req,
  input  logic [CYC_W-1:0] cfg_inj_cycle,
  input  logic [CYC_W-1:0] cfg_win_lo,
  input  logic [CYC_W-1:0] cfg_win_hi,
  input  logic [WIDTH-1:0] cfg_enable,
  input  logic [IDX_W-1:0] cfg_target,
  input  logic [1:0]       cfg_model,
  input  logic [WIDTH-1:0] dut_next,
  output logic [WIDTH-1:0] dut_state,
  output logic             dut_ce,
  output logic [CYC_W-1:0] cycle_count,
  output logic             armed,
  output logic             done,
  output logic             err
);

  run_phase_e       phase_q;
  logic [CYC_W-1:0] inj_at_q;
  logic [WIDTH-1:0] mask_q;
  logic             done_q;
  logic             err_q;

  logic [WIDTH-1:0] cand_mask;
  logic             cand_ok;
  logic             win_ok;
  logic             cfg_good;
  logic             inj_go;
  logic             adv;
  logic             wr_en;
  logic [WIDTH-1:0] wr_data;
  logic [WIDTH-1:0] rd_data;
  logic [CYC_W-1:0] count;

  seu_flip_mask #(.W(WIDTH), .IW(IDX_W)) u_mask (
    .enable (cfg_enable),
    .target (cfg_target),
    .model  (cfg_model),
    .mask   (cand_mask),
    .ok     (cand_ok)
  );

  seu_cycle_counter #(.CW(CYC_W)) u_count (
    .clk   (clk),
    .rst   (rst),
    .clr   (start),
    .inc   (adv),
    .count (count)
  );

  seu_state_file #(.W(WIDTH)) u_file (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  always_comb begin
    win_ok   = (cfg_inj_cycle >= cfg_win_lo) && (cfg_inj_cycle <= cfg_win_hi);
    cfg_good = win_ok && cand_ok;
    inj_go   = (phase_q == PH_ARMED) && (count == inj_at_q) && !start;
    adv      = (phase_q != PH_IDLE) && !inj_go && !start && (!step_mode || step_req);
    wr_en    = inj_go || adv;
    // read-modify-write of the current contents during the stolen clock
    wr_data  = inj_go ? (rd_data ^ mask_q) : dut_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      inj_at_q <= '0;
      mask_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else if (start) begin
      phase_q  <= cfg_good ? PH_ARMED : PH_SPENT;
      inj_at_q <= cfg_inj_cycle;
      mask_q   <= cand_mask;
      done_q   <= 1'b0;
      err_q    <= !cfg_good;
    end else begin
      done_q <= inj_go;
      if (inj_go) begin
        phase_q <= PH_SPENT;
      end
    end
  end

  assign dut_state   = rd_data;
  assign dut_ce      = adv;
  assign cycle_count = count;
  assign armed       = (phase_q == PH_ARMED);
  assign done        = done_q;
  assign err         = err_q;

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  single_shot_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !armed);

  // R3
  inject_hold_chk: assert property (@(posedge clk) disable iff (rst)
    inj_go |=> $stable(cycle_count));

  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (!done && !armed));

  // R9
  step_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (step_mode && !step_req && !inj_go) |=> $stable(dut_state));

  // R2
  advance_load_chk: assert property (@(posedge clk) disable iff (rst)
    dut_ce |=> (dut_state == $past(dut_next)));

endmodule

// File: tb/seu_injector_test.sv
module seu_injector_test;

  localparam int W  = 8;
  localparam int CW = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic          step_mode;
  logic          step_req;
  logic [CW-1:0] cfg_inj_cycle;
  logic [CW-1:0] cfg_win_lo;
  logic [CW-1:0] cfg_win_hi;
  logic [W-1:0]  cfg_enable;
  logic [IW-1:0] cfg_target;
  logic [1:0]    cfg_model;
  logic [W-1:0]  dut_next;
  logic [W-1:0]  dut_state;
  logic          dut_ce;
  logic [CW-1:0] cycle_count;
  logic          armed;
  logic          done;
  logic          err;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  assign dut_next = dut_state + 8'd1;

  seu_injector #(.WIDTH(W), .CYC_W(CW)) uut (
    .clk (clk), .rst (rst), .start (start), .step_mode (step_mode),
    .step_req (step_req), .cfg_inj_cycle (cfg_inj_cycle),
    .cfg_win_lo (cfg_win_lo), .cfg_win_hi (cfg_win_hi),
    .cfg_enable (cfg_enable), .cfg_target (cfg_target),
    .cfg_model (cfg_model), .dut_next (dut_next), .dut_state (dut_state),
    .dut_ce (dut_ce), .cycle_count (cycle_count), .armed (armed),
    .done (done), .err (err)
  );

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_run++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] ref_mask(input logic [W-1:0] en, input int t,
                                            input int m, output bit ok);
    logic [W-1:0] r;
    int got;
    r  = '0;
    ok = 1'b0;
    if (m > 2 || !en[t]) return '0;
    r[t] = 1'b1;
    got  = 1;
    for (int k = 1; k < W; k++) begin
      if (got < m + 1 && en[(t + k) % W]) begin
        r[(t + k) % W] = 1'b1;
        got++;
      end
    end
    ok = (got == m + 1);
    return ok ? r : '0;
  endfunction

  // starts a run at a negedge; returns at the negedge after the start edge
  task automatic kick(input logic [W-1:0] en, input int t, input int m, input int inj,
                      input int lo, input int hi, output logic [W-1:0] s0);
    cfg_enable    = en;
    cfg_target    = IW'(t);
    cfg_model     = 2'(m);
    cfg_inj_cycle = CW'(inj);
    cfg_win_lo    = CW'(lo);
    cfg_win_hi    = CW'(hi);
    start         = 1'b1;
    s0            = dut_state;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_case(input logic [W-1:0] en, input int t, input int m, input int inj,
                          input int lo, input int hi, input string req);
    logic [W-1:0] s0;
    logic [W-1:0] em;
    logic [W-1:0] want;
    bit ok;
    bit seen;
    em = ref_mask(en, t, m, ok);
    if (inj < lo || inj > hi) ok = 1'b0;
    kick(en, t, m, inj, lo, hi, s0);
    check(err == !ok, req, int'(err), int'(!ok));
    check(cycle_count == 0, "R11", int'(cycle_count), 0);
    if (ok) begin
      seen = 1'b0;
      for (int i = 0; i < inj + 4 && !seen; i++) begin
        if (done) seen = 1'b1;
        else @(negedge clk);
      end
      check(seen, "R4", int'(seen), 1);
      want = (s0 + W'(inj)) ^ em;
      check(dut_state == want, req, int'(dut_state), int'(want));
      check(cycle_count == CW'(inj), "R3", int'(cycle_count), inj);
      @(negedge clk);
      check(!done, "R4", int'(done), 0);
      check(dut_state == want + 8'd1, "R2", int'(dut_state), int'(want + 8'd1));
    end else begin
      seen = 1'b0;
      for (int i = 0; i < inj + 3; i++) begin
        @(negedge clk);
        if (done) seen = 1'b1;
      end
      check(!seen, req, int'(seen), 0);
      want = s0 + W'(inj + 3);
      check(dut_state == want, req, int'(dut_state), int'(want));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] s0;
    logic [W-1:0] masks [4];
    masks[0] = 8'hFF; masks[1] = 8'hA5; masks[2] = 8'h81; masks[3] = 8'h10;
    rst = 1'b1; start = 1'b0; step_mode = 1'b0; step_req = 1'b0;
    cfg_enable = '0; cfg_target = '0; cfg_model = '0;
    cfg_inj_cycle = '0; cfg_win_lo = '0; cfg_win_hi = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state and idle hold
    check(dut_state == 0, "R1", int'(dut_state), 0);
    check(cycle_count == 0, "R1", int'(cycle_count), 0);
    check(!done && !err && !armed, "R1", int'({done, err, armed}), 0);
    repeat (3) @(negedge clk);
    check(dut_state == 0 && !dut_ce, "R1", int'(dut_state), 0);

    // R7 sweep over masks, targets and models (R6/R8 for starved masks)
    for (int mi = 0; mi < 4; mi++)
      for (int t = 0; t < W; t++)
        for (int m = 0; m < 3; m++)
          run_case(masks[mi], t, m, (t + m) % 5, 0, 15, "R7");

    // R5 window bounds, inclusive
    run_case(8'hFF, 2, 0, 3, 3, 6, "R5");
    run_case(8'hFF, 2, 0, 6, 3, 6, "R5");
    run_case(8'hFF, 2, 0, 2, 3, 6, "R5");
    run_case(8'hFF, 2, 0, 7, 3, 6, "R5");
    // R6 target not enabled
    run_case(8'hF7, 3, 0, 2, 0, 9, "R6");
    // R8 invalid model code and starved model
    run_case(8'hFF, 1, 3, 2, 0, 9, "R8");
    run_case(8'h04, 2, 1, 2, 0, 9, "R8");
    run_case(8'h44, 6, 2, 2, 0, 9, "R8");

    // R10 settings changed after start are ignored
    kick(8'hFF, 0, 0, 3, 0, 9, s0);
    cfg_target = 3'd5; cfg_model = 2'd2; cfg_inj_cycle = 8'd1; cfg_enable = 8'h00;
    repeat (4) @(negedge clk);
    check(done == 1'b1, "R10", int'(done), 1);
    check(dut_state == ((s0 + 8'd3) ^ 8'h01), "R10", int'(dut_state),
          int'((s0 + 8'd3) ^ 8'h01));

    // R11 restart clears an error run and the counter
    kick(8'hFF, 0, 3, 2, 0, 9, s0);
    check(err == 1'b1, "R11", int'(err), 1);
    repeat (5) @(negedge clk);
    kick(8'hFF, 4, 0, 2, 0, 9, s0);
    check(!err && armed, "R11", int'({err, armed}), 1);
    check(cycle_count == 0, "R11", int'(cycle_count), 0);

    // R9 step mode
    step_mode = 1'b1;
    kick(8'hFF, 3, 0, 2, 0, 9, s0);
    repeat (3) @(negedge clk);
    check(dut_state == s0 && cycle_count == 0, "R9", int'(dut_state), int'(s0));
    for (int k = 1; k <= 2; k++) begin
      step_req = 1'b1;
      @(negedge clk);
      step_req = 1'b0;
      check(dut_state == s0 + W'(k), "R9", int'(dut_state), int'(s0 + W'(k)));
      check(cycle_count == CW'(k), "R9", int'(cycle_count), k);
    end
    @(negedge clk);
    check(done == 1'b1, "R9", int'(done), 1);
    check(dut_state == ((s0 + 8'd2) ^ 8'h08), "R9", int'(dut_state),
          int'((s0 + 8'd2) ^ 8'h08));
    repeat (3) @(negedge clk);
    check(dut_state == ((s0 + 8'd2) ^ 8'h08), "R9", int'(dut_state),
          int'((s0 + 8'd2) ^ 8'h08));
    step_mode = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule